// File: doc/BRIEF.md
# Software Write-Protect Sequence Guard

This block sits on the write path of a nonvolatile memory device group and decides, write by write, whether a write may reach the page-load logic. Each device keeps a protection flag, held in a register that stands in for the nonvolatile bit. The flag is armed or disarmed only by fixed address/data command sequences written to that device. The top address bits pick the device. The write engine reports the end of each program cycle with a done pulse and a device index.

A three-write arming sequence opens one authorized page load on the addressed device. The program cycle that follows leaves the device protected. A six-write sequence requests that protection be removed, and the request takes effect at the next program-cycle end for that device. Writes that belong to a command sequence are consumed and never reach the page-load logic. Read strobes play no part in command matching.

Top module: `swp_guard`

## Requirements
- R1: After reset every device's protected flag (`prot_o` bit) is 0 and the matcher is idle, so an ordinary write raises `wr_permit_o` in the same cycle.
- R2: An access counts as a write only when `wr_stb_i`=1 and `rd_stb_i`=0. A read strobe, alone or together with a write strobe, never raises `wr_permit_o` and never advances or resets any matcher.
- R3: The device index is `addr_i[18:17]` for writes and `prog_dev_i` for done pulses. Each device has its own matcher, window and flag, and neither commands nor done pulses affect any other device.
- R4: Command steps are matched on `addr_i[14:0]` and the 8-bit data only. Bits 16:15 are ignored, and any other address or data value is not a command step.
- R5: A write that matches the next expected step of a sequence is consumed and gives `wr_permit_o`=0. The steps are: data AA at 5555h, then 55 at 2AAAh, then either A0 at 5555h (arming) or 80 at 5555h followed by AA at 5555h, 55 at 2AAAh and 20 at 5555h (disarming).
- R6: Completing the arming sequence opens a load window on that device from the next cycle. While the window is open, every write to that device is permitted whatever its protected flag, and no command matching takes place.
- R7: A done pulse for a device with a pending arm closes its window and sets its flag. The flag reads 1 from the cycle after the pulse.
- R8: Completing the disarming sequence does not clear the flag. The flag clears after the next done pulse for that device, and writes stay blocked until then. A broken disarming sequence leaves no request behind.
- R9: On a protected device with the window closed, an ordinary write gives `wr_permit_o`=0.
- R10: A write that breaks a partly matched sequence returns the matcher to idle and is handled as an ordinary write (permitted only if unprotected). It does not itself start a new sequence, even if it is AA at 5555h.
- R11: A protected flag changes only in the cycle after a done pulse for its own device. A done pulse with nothing pending leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | Write strobe, one cycle per write |
| rd_stb_i | input | 1 | Read strobe |
| addr_i | input | 19 | Access address; top two bits select the device |
| data_i | input | 8 | Write data |
| prog_done_i | input | 1 | End-of-program-cycle pulse from the write engine |
| prog_dev_i | input | 2 | Device whose program cycle ended |
| wr_permit_o | output | 1 | Current write may proceed to page load |
| prot_o | output | 4 | Protected flag per device |

## Verification
The bench tries the arming and disarming sequences on unprotected and on protected devices, which separates permission that comes from the load window from permission that comes from the flag. Sequences are broken at each depth, including by a repeated AA at 5555h, which shows whether a breaking write restarts matching. Near-miss addresses and data, and differing address bits 16:15, show which bits the comparison uses. Reads placed inside a partial sequence and done pulses sent to the wrong device show whether state leaks between strobes and devices.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;

  // Classified meaning of one write as seen by the sequence matchers
  typedef enum logic [2:0] {
    TK_NONE,
    TK_KEY1,   // AA at 5555h
    TK_KEY2,   // 55 at 2AAAh
    TK_ARM,    // A0 at 5555h
    TK_ERASE,  // 80 at 5555h
    TK_CLEAR   // 20 at 5555h
  } swp_tok_e;

  // Matcher progress
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_E3,
    SQ_E4,
    SQ_E5
  } swp_step_e;

  localparam logic [14:0] CMD_ADDR_HI = 15'h5555;
  localparam logic [14:0] CMD_ADDR_LO = 15'h2AAA;
  localparam logic [7:0]  CMD_KEY1    = 8'hAA;
  localparam logic [7:0]  CMD_KEY2    = 8'h55;
  localparam logic [7:0]  CMD_ARM     = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CLEAR   = 8'h20;

endpackage

// File: rtl/swp_rst_sync.sv
`timescale 1ns/1ps
module swp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/swp_cmd_decode.sv
`timescale 1ns/1ps
module swp_cmd_decode
  import swp_pkg::*;
#(
  parameter int CMP_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic [CMP_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  output swp_tok_e          tok_o
);
  logic at_hi, at_lo;

  assign at_hi = (addr_i == CMP_W'(CMD_ADDR_HI));
  assign at_lo = (addr_i == CMP_W'(CMD_ADDR_LO));

  always_comb begin
    tok_o = TK_NONE;
    if (at_hi && data_i == DATA_W'(CMD_KEY1))  tok_o = TK_KEY1;
    if (at_lo && data_i == DATA_W'(CMD_KEY2))  tok_o = TK_KEY2;
    if (at_hi && data_i == DATA_W'(CMD_ARM))   tok_o = TK_ARM;
    if (at_hi && data_i == DATA_W'(CMD_ERASE)) tok_o = TK_ERASE;
    if (at_hi && data_i == DATA_W'(CMD_CLEAR)) tok_o = TK_CLEAR;
  end
endmodule

// File: rtl/swp_dev_ctl.sv
`timescale 1ns/1ps
module swp_dev_ctl
  import swp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_hit_i,    // valid write addressed to this device
  input  swp_tok_e tok_i,
  input  logic     done_hit_i,  // program cycle of this device ended
  output logic     permit_o,
  output logic     prot_o
);
  swp_step_e step_q, step_d;
  logic win_q, win_d;       // authorized load window
  logic arm_q, arm_d;       // protection set pending
  logic clr_q, clr_d;       // protection clear pending
  logic prot_q, prot_d;
  logic upd_en;
  logic ordinary;

  assign upd_en = wr_hit_i | done_hit_i;

  always_comb begin
    step_d   = step_q;
    win_d    = win_q;
    arm_d    = arm_q;
    clr_d    = clr_q;
    prot_d   = prot_q;
    permit_o = 1'b0;
    ordinary = 1'b0;

    if (done_hit_i) begin
      if (arm_q) prot_d = 1'b1;
      if (clr_q) prot_d = 1'b0;
      arm_d = 1'b0;
      clr_d = 1'b0;
      win_d = 1'b0;
    end

    if (wr_hit_i) begin
      if (win_q) begin
        permit_o = 1'b1;
      end else begin
        unique case (step_q)
          SQ_IDLE: if (tok_i == TK_KEY1) step_d = SQ_K1; else ordinary = 1'b1;
          SQ_K1:   if (tok_i == TK_KEY2) step_d = SQ_K2; else ordinary = 1'b1;
          SQ_K2: begin
            if (tok_i == TK_ARM) begin
              step_d = SQ_IDLE;
              win_d  = 1'b1;
              arm_d  = 1'b1;
              clr_d  = 1'b0;
            end else if (tok_i == TK_ERASE) begin
              step_d = SQ_E3;
            end else begin
              ordinary = 1'b1;
            end
          end
          SQ_E3:   if (tok_i == TK_KEY1) step_d = SQ_E4; else ordinary = 1'b1;
          SQ_E4:   if (tok_i == TK_KEY2) step_d = SQ_E5; else ordinary = 1'b1;
          SQ_E5: begin
            if (tok_i == TK_CLEAR) begin
              step_d = SQ_IDLE;
              clr_d  = 1'b1;
              arm_d  = 1'b0;
            end else begin
              ordinary = 1'b1;
            end
          end
          default: ordinary = 1'b1;
        endcase
        if (ordinary) begin
          step_d   = SQ_IDLE;
          permit_o = ~prot_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= SQ_IDLE;
      win_q  <= 1'b0;
      arm_q  <= 1'b0;
      clr_q  <= 1'b0;
      prot_q <= 1'b0;
    end else if (upd_en) begin
      step_q <= step_d;
      win_q  <= win_d;
      arm_q  <= arm_d;
      clr_q  <= clr_d;
      prot_q <= prot_d;
    end
  end

  assign prot_o = prot_q;
endmodule

// File: rtl/swp_guard.sv
`timescale 1ns/1ps
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int DEV_N  = 4,
  parameter int CMP_W  = 15,
  localparam int DEV_W = (DEV_N > 1) ? $clog2(DEV_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_done_i,
  input  logic [DEV_W-1:0]  prog_dev_i,
  output logic              wr_permit_o,
  output logic [DEV_N-1:0]  prot_o
);
  logic             rst_sync_n;
  logic             wr_valid;
  logic [DEV_W-1:0] dev_sel;
  logic [DEV_N-1:0] dev_permit;
  logic             unused_mid;
  swp_tok_e         tok;

  swp_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  assign wr_valid   = wr_stb_i & ~rd_stb_i;
  assign dev_sel    = addr_i[ADDR_W-1 -: DEV_W];
  assign unused_mid = ^addr_i[ADDR_W-DEV_W-1:CMP_W];

  swp_cmd_decode #(.CMP_W(CMP_W), .DATA_W(DATA_W)) dec_i (
    .addr_i (addr_i[CMP_W-1:0]),
    .data_i (data_i),
    .tok_o  (tok)
  );

  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    logic wr_hit, done_hit;
    assign wr_hit   = wr_valid    & (dev_sel    == DEV_W'(g));
    assign done_hit = prog_done_i & (prog_dev_i == DEV_W'(g));

    swp_dev_ctl ctl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .wr_hit_i   (wr_hit),
      .tok_i      (tok),
      .done_hit_i (done_hit),
      .permit_o   (dev_permit[g]),
      .prot_o     (prot_o[g])
    );
  end

  assign wr_permit_o = |dev_permit;
endmodule

// File: rtl/swp_guard_chk.sv
`timescale 1ns/1ps
module swp_guard_chk #(
  parameter int DEV_N = 4,
  parameter int DEV_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_stb_i,
  input logic             rd_stb_i,
  input logic             prog_done_i,
  input logic [DEV_W-1:0] prog_dev_i,
  input logic             wr_permit_o,
  input logic [DEV_N-1:0] prot_o,
  input logic [DEV_N-1:0] dev_permit
);
  // R2
  permit_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o |-> (wr_stb_i && !rd_stb_i));

  // R3
  single_dev_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_permit));

  // R11
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_done_i |=> $stable(prot_o));

  // R11
  flag_own_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_done_i |=> (((prot_o ^ $past(prot_o)) & ~(DEV_N'(1) << $past(prog_dev_i))) == '0));
endmodule

bind swp_guard swp_guard_chk #(.DEV_N(DEV_N), .DEV_W(DEV_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .wr_stb_i    (wr_stb_i),
  .rd_stb_i    (rd_stb_i),
  .prog_done_i (prog_done_i),
  .prog_dev_i  (prog_dev_i),
  .wr_permit_o (wr_permit_o),
  .prot_o      (prot_o),
  .dev_permit  (dev_permit)
);

// File: tb/swp_guard_tb.sv
`timescale 1ns/1ps
module swp_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb, rd_stb, done;
  logic [18:0] addr;
  logic [7:0]  data;
  logic [1:0]  done_dev;
  logic        wr_permit;
  logic [3:0]  prot;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  bit last_perm;

  always #2.5 clk = ~clk;

  swp_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb),
    .addr_i(addr), .data_i(data), .prog_done_i(done), .prog_dev_i(done_dev),
    .wr_permit_o(wr_permit), .prot_o(prot)
  );

  // ---------------- behavioural reference ----------------
  int m_step[4];
  bit m_win[4], m_arm[4], m_clr[4], m_prot[4];

  task automatic note(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void eval_w(input int d, input logic [14:0] a, input logic [7:0] v,
                                 output bit perm, output string tag, output int ns,
                                 output bit open_w, output bit req_clr);
    bit k1, k2, arm, ers, clr, ord;
    k1  = (a == 15'h5555 && v == 8'hAA);
    k2  = (a == 15'h2AAA && v == 8'h55);
    arm = (a == 15'h5555 && v == 8'hA0);
    ers = (a == 15'h5555 && v == 8'h80);
    clr = (a == 15'h5555 && v == 8'h20);
    perm = 0; tag = "R5"; ns = m_step[d]; open_w = 0; req_clr = 0; ord = 0;
    if (m_win[d]) begin
      perm = 1; tag = "R6"; ns = 0;
    end else begin
      case (m_step[d])
        0: if (k1) ns = 1; else ord = 1;
        1: if (k2) ns = 2; else ord = 1;
        2: if (arm) begin ns = 0; open_w = 1; end else if (ers) ns = 3; else ord = 1;
        3: if (k1) ns = 4; else ord = 1;
        4: if (k2) ns = 5; else ord = 1;
        default: if (clr) begin ns = 0; req_clr = 1; end else ord = 1;
      endcase
      if (ord) begin
        tag  = (m_step[d] != 0) ? "R10" : (m_prot[d] ? "R9" : "R1");
        perm = !m_prot[d];
        ns   = 0;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_step[i] = 0; m_win[i] = 0; m_arm[i] = 0; m_clr[i] = 0; m_prot[i] = 0;
      end
    end else begin
      bit p, ow, rc; string t; int ns; int d;
      d = int'(addr[18:17]);
      if (wr_stb && !rd_stb) eval_w(d, addr[14:0], data, p, t, ns, ow, rc);
      if (done) begin
        if (m_arm[done_dev]) m_prot[done_dev] = 1;
        if (m_clr[done_dev]) m_prot[done_dev] = 0;
        m_arm[done_dev] = 0; m_clr[done_dev] = 0; m_win[done_dev] = 0;
      end
      if (wr_stb && !rd_stb) begin
        m_step[d] = ns;
        if (ow) begin m_win[d] = 1; m_arm[d] = 1; m_clr[d] = 0; end
        if (rc) begin m_clr[d] = 1; m_arm[d] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit p, ow, rc; string t; int ns; bit exp_p;
      exp_p = 0; t = "R2";
      if (wr_stb && !rd_stb) eval_w(int'(addr[18:17]), addr[14:0], data, p, t, ns, ow, rc);
      if (wr_stb && !rd_stb) exp_p = p;
      note(wr_permit === exp_p, t, int'(wr_permit), int'(exp_p));
      for (int i = 0; i < 4; i++)
        note(prot[i] === m_prot[i], "R11", int'(prot[i]), int'(m_prot[i]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic acc(input int d, input logic [14:0] a, input logic [7:0] v,
                     input bit w = 1, input bit r = 0, input logic [1:0] mid = 2'b00);
    wr_stb = w; rd_stb = r;
    addr = {d[1:0], mid, a}; data = v;
    @(negedge clk);
    last_perm = wr_permit;
    @(posedge clk); #1;
    wr_stb = 0; rd_stb = 0;
  endtask

  task automatic wchk(input int d, input logic [14:0] a, input logic [7:0] v,
                      input bit exp, input string tag);
    acc(d, a, v);
    note(last_perm == exp, tag, int'(last_perm), int'(exp));
  endtask

  task automatic pulse(input int d);
    done = 1; done_dev = d[1:0];
    @(posedge clk); #1;
    done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_stb = 0; rd_stb = 0; done = 0; done_dev = 0; addr = '0; data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state and open writes
    note(prot == 4'b0000, "R1", int'(prot), 0);
    wchk(0, 15'h0123, 8'h5A, 1, "R1");

    // R4/R5/R6/R7: arm device 0, key with mid bits set
    acc(0, 15'h5555, 8'hAA, 1, 0, 2'b11);
    note(last_perm == 0, "R4", int'(last_perm), 0);
    wchk(0, 15'h2AAA, 8'h55, 0, "R5");
    wchk(0, 15'h5555, 8'hA0, 0, "R5");
    wchk(0, 15'h0100, 8'h11, 1, "R6");
    wchk(0, 15'h0101, 8'h22, 1, "R6");
    note(prot[0] == 0, "R7", int'(prot[0]), 0);
    pulse(0);
    note(prot == 4'b0001, "R7", int'(prot), 1);

    // R9/R3
    wchk(0, 15'h0102, 8'h33, 0, "R9");
    wchk(1, 15'h0102, 8'h33, 1, "R3");

    // R10: repeated key does not restart
    wchk(1, 15'h5555, 8'hAA, 0, "R5");
    wchk(1, 15'h5555, 8'hAA, 1, "R10");
    wchk(1, 15'h2AAA, 8'h55, 1, "R10");

    // R10 on protected device: broken sequence gives no window
    wchk(0, 15'h5555, 8'hAA, 0, "R5");
    wchk(0, 15'h1234, 8'h55, 0, "R10");
    wchk(0, 15'h2AAA, 8'h55, 0, "R10");
    wchk(0, 15'h5555, 8'hA0, 0, "R10");
    wchk(0, 15'h0400, 8'h99, 0, "R10");

    // R4: near misses are ordinary
    wchk(1, 15'h5554, 8'hAA, 1, "R4");
    wchk(1, 15'h5555, 8'hA5, 1, "R4");

    // R2: reads inside a sequence are ignored
    wchk(0, 15'h5555, 8'hAA, 0, "R5");
    acc(0, 15'h2AAA, 8'h55, 0, 1);
    note(last_perm == 0, "R2", int'(last_perm), 0);
    acc(0, 15'h0777, 8'h44, 1, 1);
    note(last_perm == 0, "R2", int'(last_perm), 0);
    wchk(0, 15'h2AAA, 8'h55, 0, "R5");
    wchk(0, 15'h5555, 8'hA0, 0, "R5");
    wchk(0, 15'h0200, 8'h66, 1, "R2");
    wchk(0, 15'h5555, 8'hAA, 1, "R6");
    pulse(0);
    note(prot == 4'b0001, "R7", int'(prot), 1);
    acc(1, 15'h0010, 8'h01, 1, 1);
    note(last_perm == 0, "R2", int'(last_perm), 0);

    // R8: disarm device 0
    wchk(0, 15'h5555, 8'hAA, 0, "R8");
    wchk(0, 15'h2AAA, 8'h55, 0, "R8");
    wchk(0, 15'h5555, 8'h80, 0, "R8");
    wchk(0, 15'h5555, 8'hAA, 0, "R8");
    wchk(0, 15'h2AAA, 8'h55, 0, "R8");
    wchk(0, 15'h5555, 8'h20, 0, "R8");
    wchk(0, 15'h0300, 8'h77, 0, "R8");
    note(prot[0] == 1, "R8", int'(prot[0]), 1);
    pulse(0);
    note(prot[0] == 0, "R8", int'(prot[0]), 0);
    wchk(0, 15'h0300, 8'h77, 1, "R8");

    // R3/R11: done pulses act on their own device only
    wchk(2, 15'h5555, 8'hAA, 0, "R5");
    wchk(2, 15'h2AAA, 8'h55, 0, "R5");
    wchk(2, 15'h5555, 8'hA0, 0, "R5");
    pulse(3);
    note(prot == 4'b0000, "R3", int'(prot), 0);
    pulse(2);
    note(prot == 4'b0100, "R11", int'(prot), 4);
    wchk(2, 15'h0050, 8'h05, 0, "R9");

    // R8: broken disarm leaves no request
    wchk(2, 15'h5555, 8'hAA, 0, "R5");
    wchk(2, 15'h2AAA, 8'h55, 0, "R5");
    wchk(2, 15'h5555, 8'h80, 0, "R5");
    wchk(2, 15'h5555, 8'hAA, 0, "R5");
    wchk(2, 15'h5555, 8'h20, 0, "R10");
    pulse(2);
    note(prot[2] == 1, "R8", int'(prot[2]), 1);
    pulse(1);
    note(prot[1] == 0, "R11", int'(prot[1]), 0);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule